// File: doc/BRIEF.md
# Cartridge Save-Memory Access Controller

This block sits on the cartridge side of a 24-bit CPU bus and owns the battery-backed save area. A small mode register sets whether the save window may be read and whether writes into it are blocked. The block works out by itself whether the cartridge carries a plain byte-wide SRAM or a two-address serial EEPROM. It does this by watching the first accesses that land in the save window.

In SRAM operation, byte and word accesses inside the window go to an internal byte array. A sticky dirty flag rises the first time a write really alters a stored byte. Once the EEPROM type has been detected, the window collapses to a pair of byte addresses and every access there goes to an external EEPROM engine through a small request hook instead. Writes toward that engine are paced by a cycle timestamp supplied from outside: a write that follows the last committed one too closely only refreshes the pending state.

The bus is single-cycle. Read data and hook strobes are combinational on the request. Register, array and timestamp updates take effect at the clock edge that ends the request.

Top module: `savemem_ctrl`

## Requirements
- R1: After reset the mode register reads 0x00 and `dirty` is low. Reads into the window are not claimed: `bus_hit` is 0 and `bus_rdata` is 0.
- R2: A byte write to address 0xA130F1 loads mode bit 0 (read enable) and bit 1 (write protect) from `bus_wdata[1:0]`, and clears bit 2 (EEPROM mode) and bit 4 (type detected). All other mode bits read as zero.
- R3: Outside EEPROM mode, a window read with mode bit 0 clear is not claimed: `bus_hit` is 0 and `bus_rdata` is 0.
- R4: Outside EEPROM mode with write protect clear, a byte write stores `bus_wdata[7:0]`. A byte read with bit 0 set returns that byte in `bus_rdata[7:0]`, with `bus_rdata[15:8]` zero.
- R5: A word access uses the even address at or below `bus_addr`. A word write stores `bus_wdata[15:8]` at the even byte and `bus_wdata[7:0]` at the odd byte. A word read returns the even byte in `[15:8]` and the odd byte in `[7:0]`.
- R6: With write protect set, window writes leave the array and `dirty` unchanged.
- R7: `dirty` rises only on a write that changes a stored byte (array bytes reset to 0x00), and it stays high until reset.
- R8: The first window write while bit 4 is clear sets bit 4. If that write's address is 0x200000 or 0x200001, it also sets bit 2 and narrows the window to those two bytes. The write itself is routed by the mode held before it.
- R9: A byte read while bit 4 is clear and bit 0 is set, at an address above 0x200001, sets bit 4. Byte reads at 0x200000/0x200001 and all word reads leave bit 4 unchanged.
- R10: In EEPROM mode, a window read raises `eep_rd`, sets `bus_hit` and returns `{8'h00, eep_rdata}`. Window writes never modify the array.
- R11: In EEPROM mode, every window write raises `eep_upd`. `eep_commit` is also raised, and the commit time becomes `cyc_now`, only when `cyc_now` minus the last commit time (reset 0) is at least 46.
- R12: Once narrowed, addresses outside 0x200000..0x200001 are not claimed and raise no hook strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 16 | Write data (byte writes use [7:0]) |
| bus_rdata | output | 16 | Read data, 0 when not claimed |
| bus_hit | output | 1 | Read claimed by this block |
| cyc_now | input | 32 | Free-running cycle timestamp |
| eep_rd | output | 1 | EEPROM read request |
| eep_rdata | input | 8 | EEPROM read data |
| eep_upd | output | 1 | Update EEPROM pending state |
| eep_commit | output | 1 | Commit pending EEPROM state before the update |
| eep_abit | output | 1 | Address bit 0 of the EEPROM access |
| eep_wdata | output | 8 | EEPROM write byte |
| mode_q | output | 8 | Mode register |
| dirty | output | 1 | Save contents changed |

## Verification
The hardest states to reach are the ones that depend on detection history. Two examples are the narrowed window after the mode register has been rewritten, and the detecting write itself, which lands in the array even though the block is already in EEPROM mode afterwards. The bench reaches them by triggering detection with a write to 0x200001, then rewriting the mode register to clear the EEPROM bit. Reading back through the still-narrowed window then shows which bytes the array really holds. The pacing of EEPROM writes is driven by stepping the external timestamp to exactly 45 and 46 cycles past the last commit.

// File: rtl/savemem_pkg.sv
package savemem_pkg;
   localparam int ADDR_W = 24;

   typedef struct packed {
      logic [2:0] spare_hi;
      logic       det;
      logic       spare3;
      logic       eep;
      logic       wprot;
      logic       rd_en;
   } mode_t;
endpackage

// File: rtl/savemem_mode.sv
module savemem_mode
   import savemem_pkg::*;
#(
   parameter logic [ADDR_W-1:0] WIN_LO    = 24'h200000,
   parameter logic [ADDR_W-1:0] WIN_HI    = 24'h2003FF,
   parameter logic [ADDR_W-1:0] EEP_ADDR  = 24'h200000,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 24'hA130F1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              we,
   input  logic              word,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        wbits,
   output logic              in_win,
   output mode_t             mode_q
);
   localparam logic [ADDR_W-1:0] EEP_LAST = EEP_ADDR + 24'd1;

   logic              narrow_q;
   logic [ADDR_W-1:0] lo, hi;
   logic              mode_wr, win_wr, rd_det, eep_hit;

   assign lo      = narrow_q ? EEP_ADDR : WIN_LO;
   assign hi      = narrow_q ? EEP_LAST : WIN_HI;
   assign in_win  = (addr >= lo) && (addr <= hi);
   assign mode_wr = valid && we && !word && (addr == MODE_ADDR) && !in_win;
   assign win_wr  = valid && we && in_win && !mode_q.det;
   assign rd_det  = valid && !we && !word && in_win && !mode_q.det &&
                    mode_q.rd_en && (addr > EEP_LAST);
   assign eep_hit = (addr[ADDR_W-1:1] == EEP_ADDR[ADDR_W-1:1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         narrow_q <= 1'b0;
      end else if (mode_wr) begin
         mode_q       <= '0;
         mode_q.rd_en <= wbits[0];
         mode_q.wprot <= wbits[1];
      end else if (win_wr) begin
         mode_q.det <= 1'b1;
         if (eep_hit) begin
            mode_q.eep <= 1'b1;
            narrow_q   <= 1'b1;
         end
      end else if (rd_det) begin
         mode_q.det <= 1'b1;
      end
   end

   // R8: detection flag only drops through a mode register write
   p_det_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_q.det) && !$past(mode_wr)) |-> mode_q.det);
   // R8: EEPROM mode never exists without detection
   p_eep_det_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q.eep |-> mode_q.det);
   // R12: EEPROM mode always comes with the narrowed window
   p_eep_narrow_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q.eep |-> narrow_q);
endmodule

// File: rtl/savemem_array.sv
module savemem_array #(
   parameter int DEPTH = 1024,
   localparam int IW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_word,
   input  logic [IW-1:0] idx,
   input  logic [15:0]   wdata,
   output logic [7:0]    rd_even,
   output logic [7:0]    rd_at,
   output logic [7:0]    rd_odd,
   output logic          dirty_q
);
   logic [DEPTH*8-1:0] flat;
   logic [IW-1:0]      idx_e, idx_o;
   logic               chg;

   assign idx_e = {idx[IW-1:1], 1'b0};
   assign idx_o = {idx[IW-1:1], 1'b1};

   for (genvar i = 0; i < DEPTH; i++) begin : g_byte
      localparam logic [IW-1:0] ME = IW'(i);
      logic [7:0] byte_q;
      logic       we_i;
      logic [7:0] d_i;
      assign we_i = wr_en && (wr_word ? (idx[IW-1:1] == ME[IW-1:1]) : (idx == ME));
      if (i % 2 == 0) begin : g_even
         assign d_i = wr_word ? wdata[15:8] : wdata[7:0];
      end else begin : g_odd
         assign d_i = wdata[7:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    byte_q <= '0;
         else if (we_i) byte_q <= d_i;
      end
      assign flat[i*8 +: 8] = byte_q;
   end

   assign rd_even = flat[idx_e*8 +: 8];
   assign rd_odd  = flat[idx_o*8 +: 8];
   assign rd_at   = flat[idx*8 +: 8];

   assign chg = wr_word ? ((rd_even != wdata[15:8]) || (rd_odd != wdata[7:0]))
                        : (rd_at != wdata[7:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             dirty_q <= 1'b0;
      else if (wr_en && chg)  dirty_q <= 1'b1;
   end

   // R7: once raised, the flag holds
   p_dirty_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(dirty_q) |-> dirty_q);
   // R7: the flag only rises after an array write
   p_dirty_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dirty_q) |-> $past(wr_en));
endmodule

// File: rtl/savemem_eep_gate.sv
module savemem_eep_gate #(
   parameter int CYC_W = 32,
   parameter int GAP   = 46
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CYC_W-1:0] cyc_now,
   output logic             upd,
   output logic             commit
);
   logic [CYC_W-1:0] last_q;
   logic [CYC_W-1:0] since;

   assign since  = cyc_now - last_q;
   assign upd    = wr;
   assign commit = wr && (since >= CYC_W'(GAP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      last_q <= '0;
      else if (commit) last_q <= cyc_now;
   end

   // R11: the commit time moves only on a commit
   p_last_moves_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(last_q) |-> $past(commit));
endmodule

// File: rtl/savemem_ctrl.sv
module savemem_ctrl
   import savemem_pkg::*;
#(
   parameter logic [ADDR_W-1:0] WIN_LO    = 24'h200000,
   parameter logic [ADDR_W-1:0] WIN_HI    = 24'h2003FF,
   parameter logic [ADDR_W-1:0] EEP_ADDR  = 24'h200000,
   parameter logic [ADDR_W-1:0] MODE_ADDR = 24'hA130F1,
   parameter int                CYC_W     = 32,
   parameter int                EEP_GAP   = 46
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_we,
   input  logic              bus_word,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              bus_hit,
   input  logic [CYC_W-1:0]  cyc_now,
   output logic              eep_rd,
   input  logic [7:0]        eep_rdata,
   output logic              eep_upd,
   output logic              eep_commit,
   output logic              eep_abit,
   output logic [7:0]        eep_wdata,
   output logic [7:0]        mode_q,
   output logic              dirty
);
   localparam int DEPTH = int'(WIN_HI - WIN_LO) + 1;
   localparam int IW    = $clog2(DEPTH);

   if (WIN_HI < WIN_LO)           $error("save window end below start");
   if (WIN_LO[0] != 1'b0)         $error("save window must start even");
   if (DEPTH % 2 != 0)            $error("save window size must be even");
   if (EEP_ADDR < WIN_LO || EEP_ADDR + 24'd1 > WIN_HI || EEP_ADDR[0] != 1'b0)
                                  $error("EEPROM pair must be an even pair inside the window");
   if (MODE_ADDR >= WIN_LO && MODE_ADDR <= WIN_HI)
                                  $error("mode register inside save window");
   if (EEP_GAP < 1)               $error("EEPROM gap must be positive");

   mode_t             mode;
   logic              in_win, rd_claim, arr_wr, eep_wr;
   logic [ADDR_W-1:0] offs;
   logic [IW-1:0]     idx;
   logic [7:0]        b_even, b_at, b_odd;

   savemem_mode #(
      .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .EEP_ADDR(EEP_ADDR), .MODE_ADDR(MODE_ADDR)
   ) u_mode (
      .clk(clk), .rst_n(rst_n), .valid(bus_valid), .we(bus_we), .word(bus_word),
      .addr(bus_addr), .wbits(bus_wdata[1:0]), .in_win(in_win), .mode_q(mode)
   );

   assign offs     = bus_addr - WIN_LO;
   assign idx      = offs[IW-1:0];
   assign rd_claim = bus_valid && !bus_we && in_win && (mode.eep || mode.rd_en);
   assign arr_wr   = bus_valid && bus_we && in_win && !mode.eep && !mode.wprot;
   assign eep_wr   = bus_valid && bus_we && in_win && mode.eep;

   savemem_array #(.DEPTH(DEPTH)) u_array (
      .clk(clk), .rst_n(rst_n), .wr_en(arr_wr), .wr_word(bus_word), .idx(idx),
      .wdata(bus_wdata), .rd_even(b_even), .rd_at(b_at), .rd_odd(b_odd),
      .dirty_q(dirty)
   );

   savemem_eep_gate #(.CYC_W(CYC_W), .GAP(EEP_GAP)) u_gate (
      .clk(clk), .rst_n(rst_n), .wr(eep_wr), .cyc_now(cyc_now),
      .upd(eep_upd), .commit(eep_commit)
   );

   always_comb begin
      if (!rd_claim)     bus_rdata = '0;
      else if (mode.eep) bus_rdata = {8'h00, eep_rdata};
      else if (bus_word) bus_rdata = {b_even, b_odd};
      else               bus_rdata = {8'h00, b_at};
   end

   assign bus_hit   = rd_claim;
   assign eep_rd    = rd_claim && mode.eep;
   assign eep_abit  = bus_addr[0];
   assign eep_wdata = bus_wdata[7:0];
   assign mode_q    = mode;

   // R10: EEPROM writes never reach the array
   p_eep_no_array_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eep_upd |-> !arr_wr);
   // R6: protected writes never reach the array
   p_wprot_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
      arr_wr |-> !mode.wprot);
   // R10: a hook read is always a claimed read
   p_rd_hook_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eep_rd |-> bus_hit);
   // R11: a commit always comes with an update
   p_commit_upd_r11: assert property (@(posedge clk) disable iff (!rst_n)
      eep_commit |-> eep_upd);
endmodule

// File: tb/savemem_ctrl_tb.sv
module savemem_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_we = 1'b0, bus_word = 1'b0;
   logic [23:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_hit;
   logic [31:0] cyc_now = '0;
   logic        eep_rd, eep_upd, eep_commit, eep_abit;
   logic [7:0]  eep_rdata = 8'h05;
   logic [7:0]  eep_wdata, mode_q;
   logic        dirty;

   int n_run = 0, n_fail = 0;
   logic [15:0] rd_s;
   logic        hit_s, upd_s, cmt_s, erd_s;

   always #4 clk = ~clk;

   savemem_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
      .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_hit(bus_hit), .cyc_now(cyc_now),
      .eep_rd(eep_rd), .eep_rdata(eep_rdata), .eep_upd(eep_upd),
      .eep_commit(eep_commit), .eep_abit(eep_abit), .eep_wdata(eep_wdata),
      .mode_q(mode_q), .dirty(dirty)
   );

   typedef struct packed {
      logic        we;
      logic        word;
      logic [23:0] addr;
      logic [15:0] wd;
      logic [15:0] exp_rd;
      logic        exp_hit;
   } vec_t;

   // R4/R5 traffic with mode 0x01 after a fresh reset
   localparam vec_t VECS [8] = '{
      '{1'b1, 1'b0, 24'h200010, 16'h005A, 16'h0000, 1'b0},
      '{1'b0, 1'b0, 24'h200010, 16'h0000, 16'h005A, 1'b1},
      '{1'b1, 1'b0, 24'h200011, 16'h00C3, 16'h0000, 1'b0},
      '{1'b0, 1'b1, 24'h200010, 16'h0000, 16'h5AC3, 1'b1},
      '{1'b1, 1'b1, 24'h200020, 16'h1234, 16'h0000, 1'b0},
      '{1'b0, 1'b0, 24'h200021, 16'h0000, 16'h0034, 1'b1},
      '{1'b0, 1'b0, 24'h200020, 16'h0000, 16'h0012, 1'b1},
      '{1'b0, 1'b1, 24'h200021, 16'h0000, 16'h1234, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic op(input logic we, input logic word, input logic [23:0] a,
                     input logic [15:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_we = we; bus_word = word; bus_addr = a; bus_wdata = d;
      #1;
      rd_s = bus_rdata; hit_s = bus_hit; upd_s = eep_upd; cmt_s = eep_commit; erd_s = eep_rd;
      @(posedge clk);
      #1 bus_valid = 1'b0; bus_we = 1'b0; bus_word = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R1 reset state
      do_reset();
      chk("R1 mode", mode_q, 8'h00);
      chk("R1 dirty", dirty, 0);
      op(0, 0, 24'h200010, 0);
      chk("R1 hit", hit_s, 0);
      chk("R1 rdata", rd_s, 0);

      // R2 mode load, R8 first write not at pair, R6 protect
      op(1, 0, 24'hA130F1, 16'h00FF);
      chk("R2 mode", mode_q, 8'h03);
      op(1, 0, 24'h200010, 16'h005A);
      chk("R8 det only", mode_q, 8'h13);
      op(0, 0, 24'h200010, 0);
      chk("R6 protected data", rd_s, 16'h0000);
      chk("R6 protected hit", hit_s, 1);
      chk("R6 dirty", dirty, 0);
      op(1, 0, 24'hA130F1, 16'h0001);
      chk("R2 clears det", mode_q, 8'h01);

      // table walk
      do_reset();
      op(1, 0, 24'hA130F1, 16'h0001);
      foreach (VECS[i]) begin
         op(VECS[i].we, VECS[i].word, VECS[i].addr, VECS[i].wd);
         chk($sformatf("R%0d vec%0d rdata", VECS[i].word ? 5 : 4, i), rd_s, VECS[i].exp_rd);
         chk($sformatf("R%0d vec%0d hit", VECS[i].word ? 5 : 4, i), hit_s, VECS[i].exp_hit);
      end
      chk("R7 dirty after change", dirty, 1);

      // R3 read disabled
      op(1, 0, 24'hA130F1, 16'h0000);
      op(0, 0, 24'h200010, 0);
      chk("R3 hit", hit_s, 0);
      chk("R3 rdata", rd_s, 0);

      // R7 same-value write keeps dirty low
      do_reset();
      op(1, 0, 24'hA130F1, 16'h0001);
      op(1, 0, 24'h200030, 16'h0000);
      chk("R7 unchanged byte", dirty, 0);
      op(1, 0, 24'h200030, 16'h0077);
      chk("R7 changed byte", dirty, 1);

      // R9 read-based detection
      do_reset();
      op(1, 0, 24'hA130F1, 16'h0001);
      op(0, 0, 24'h200001, 0);
      chk("R9 pair read no det", mode_q, 8'h01);
      op(0, 1, 24'h200010, 0);
      chk("R9 word read no det", mode_q, 8'h01);
      op(0, 0, 24'h200002, 0);
      chk("R9 byte read det", mode_q, 8'h11);

      // R8 EEPROM detection, R10/R11/R12 hook behaviour
      do_reset();
      op(1, 0, 24'hA130F1, 16'h0001);
      op(1, 0, 24'h200001, 16'h00AB);
      chk("R8 detecting write not to hook", upd_s, 0);
      chk("R8 eep mode", mode_q, 8'h15);
      cyc_now = 32'd1000;
      op(1, 0, 24'h200000, 16'h0001);
      chk("R11 first commit", {upd_s, cmt_s}, 2'b11);
      cyc_now = 32'd1045;
      op(1, 0, 24'h200000, 16'h0002);
      chk("R11 gap 45 update only", {upd_s, cmt_s}, 2'b10);
      cyc_now = 32'd1046;
      op(1, 0, 24'h200000, 16'h0003);
      chk("R11 gap 46 commit", {upd_s, cmt_s}, 2'b11);
      cyc_now = 32'd1050;
      op(1, 0, 24'h200001, 16'h0004);
      chk("R11 new base", {upd_s, cmt_s}, 2'b10);
      op(0, 0, 24'h200001, 0);
      chk("R10 hook read data", rd_s, 16'h0005);
      chk("R10 hook read strobe", {hit_s, erd_s}, 2'b11);
      op(0, 0, 24'h200002, 0);
      chk("R12 outside pair read", {hit_s, erd_s}, 2'b00);
      op(1, 0, 24'h200004, 16'h0009);
      chk("R12 outside pair write", upd_s, 0);
      op(1, 0, 24'hA130F1, 16'h0001);
      chk("R2 clears eep", mode_q, 8'h01);
      op(0, 1, 24'h200000, 0);
      chk("R10 array untouched by hook writes", rd_s, 16'h00AB);
      op(0, 0, 24'h200004, 0);
      chk("R12 narrowed after mode rewrite", hit_s, 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule